// File: doc/BRIEF.md
# Multi-Protocol Host Register Interface

This block is an 8-bit host bus slave that holds 32 byte-wide configuration registers. A 3-bit strap, `mode_sel`, picks the host bus style at run time. The three supported styles are:

- a multiplexed address/data bus framed by an address latch strobe;
- a split address/data bus with separate active-low read and write strobes;
- a split bus with one read/write-bar line and an active-low transfer acknowledge.

Any other strap code leaves every bus pin undriven and ignores all host activity.

Host strobes are asynchronous to the system clock. Each strobe is taken through a two-flop synchroniser. A write lands in the register bank when its strobe is released. The handshake output asserts once the synchronised strobe has been seen, and it stays asserted until the host lets go.

The whole bank is exported as one flat vector for the device logic. Register n sits at bits 8n+7..8n. Multi-byte values therefore read little-endian, with byte 0 at the lowest address.

Top module: `hostreg_if`

## Requirements
- R1: Only `mode_sel` codes 2, 3 and 4 enable the interface. For codes 0, 1, 5, 6 and 7, the following hold: `ad`, `dbus`, `rdy` and `dtack_n` are high impedance, no read data is driven, and strobes write nothing.
- R2: After reset, all 32 registers read zero on `cfg_q`.
- R3: In mode 2, the register address is AD[4:0] as held when `ale` falls. AD must stay stable for 4 clocks after the fall, and the captured address serves the following strobe.
- R4: In mode 2, `ad` carries the addressed register while `cs_n` and `rd_n` are both low. At all other times `ad` is high impedance.
- R5: In mode 3, `addr` selects the register and `dbus` carries data. `dbus` is driven only while `cs_n` and `rd_n` are both low, and `wr_n` low writes.
- R6: In mode 4, a cycle lasts while `cs_n` is low. `rw_sel` high reads and drives `dbus`; `rw_sel` low writes.
- R7: A write commits only after its strobe deasserts. While the strobe is held, the register keeps its old value. The new value is visible on `cfg_q` within 4 clocks of the release.
- R8: The handshake is `rdy` high in modes 2 and 3, or `dtack_n` low in mode 4. It asserts 3 clocks after the strobe becomes active, holds while the strobe stays active, and clears within 4 clocks of the release.
- R9: Register n occupies `cfg_q[8n+7:8n]`, so registers 4 and 5 together form a little-endian 16-bit value.
- R10: With `cs_n` high, read and write strobes have no effect: no register changes and the handshake stays inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 3 | Bus style strap |
| cs_n | input | 1 | Active-low chip select |
| ale | input | 1 | Address latch strobe (mode 2) |
| rd_n | input | 1 | Active-low read strobe (modes 2, 3) |
| wr_n | input | 1 | Active-low write strobe (modes 2, 3) |
| rw_sel | input | 1 | Read high / write low (mode 4) |
| addr | input | 5 | Register address (modes 3, 4) |
| ad | inout | 8 | Multiplexed address/data (mode 2) |
| dbus | inout | 8 | Data bus (modes 3, 4) |
| rdy | output | 1 | Ready, active high (modes 2, 3) |
| dtack_n | output | 1 | Transfer acknowledge, active low (mode 4) |
| cfg_q | output | 256 | Flat register bank contents |

## Verification
The bench holds a write strobe for several clocks and checks that the target register keeps its old value during that time. A design that commits on the leading edge of the strobe would already show the new byte there. For every disabled strap code, the bench attempts a read and a write. It catches a design that drives the bus, answers with a handshake, or writes the bank while it should be inert. The bench also pulses strobes with chip select high, and it checks little-endian placement across a register pair. These checks expose a design that ignores chip select or packs the bank in the wrong order. Each mode's read path is checked for high impedance once the read ends, which exposes a bus driver left enabled.

// File: rtl/hostreg_if.sv
module hostreg_if #(
  parameter int AW = 5,
  parameter int DW = 8,
  localparam int NREG = 1 << AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode_sel,
  input  logic             cs_n,
  input  logic             ale,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             rw_sel,
  input  logic [AW-1:0]    addr,
  inout  wire  [DW-1:0]    ad,
  inout  wire  [DW-1:0]    dbus,
  output wire              rdy,
  output wire              dtack_n,
  output logic [NREG*DW-1:0] cfg_q
);
  localparam logic [2:0] M_MUX = 3'd2;
  localparam logic [2:0] M_SEP = 3'd3;
  localparam logic [2:0] M_RWB = 3'd4;

  wire m_mux = mode_sel == M_MUX;
  wire m_sep = mode_sel == M_SEP;
  wire m_rwb = mode_sel == M_RWB;
  wire en    = m_mux | m_sep | m_rwb;

  logic [DW-1:0] regs [NREG];
  logic [AW-1:0] alat, wadr;
  logic [DW-1:0] wdat, din_s1, din_s2;
  logic [AW-1:0] ain_s1, ain_s2;
  logic [1:0]    act_sy, ale_sy, wr_sy;
  logic          ale_q, act_q, wflag, ack;

  wire act_pin = en & ~cs_n & (m_rwb | ~rd_n | ~wr_n);
  wire wr_pin  = m_rwb ? ~rw_sel : ~wr_n;
  wire rd_pin  = en & ~cs_n & (m_rwb ? rw_sel : ~rd_n);
  wire [DW-1:0] din = m_mux ? ad : dbus;
  wire act_s = act_sy[1];
  wire we    = act_q & ~act_s & wflag;

  wire [AW-1:0] raddr = m_mux ? alat : addr;
  wire [DW-1:0] rdata = regs[raddr];

  assign ad      = (m_mux & rd_pin) ? rdata : {DW{1'bz}};
  assign dbus    = ((m_sep | m_rwb) & rd_pin) ? rdata : {DW{1'bz}};
  assign rdy     = (m_mux | m_sep) ? ack : 1'bz;
  assign dtack_n = m_rwb ? ~ack : 1'bz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_sy <= '0;
      ale_sy <= '0;
      wr_sy  <= '0;
      din_s1 <= '0;
      din_s2 <= '0;
      ain_s1 <= '0;
      ain_s2 <= '0;
      ale_q  <= 1'b0;
      alat   <= '0;
    end else begin
      act_sy <= {act_sy[0], act_pin};
      ale_sy <= {ale_sy[0], ale & m_mux};
      wr_sy  <= {wr_sy[0], wr_pin};
      din_s1 <= din;
      din_s2 <= din_s1;
      ain_s1 <= addr;
      ain_s2 <= ain_s1;
      ale_q  <= ale_sy[1];
      if (ale_q && !ale_sy[1]) alat <= din_s2[AW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ack   <= 1'b0;
      wflag <= 1'b0;
      wdat  <= '0;
      wadr  <= '0;
    end else begin
      act_q <= act_s;
      ack   <= act_s;
      if (act_s) begin
        wflag <= wr_sy[1];
        wdat  <= din_s2;
        wadr  <= m_mux ? alat : ain_s2;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wadr] <= wdat;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign cfg_q[g*DW +: DW] = regs[g];
  end
endmodule

module hostreg_if_chk #(
  parameter int W = 256
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         act_s,
  input logic         ack,
  input logic         we,
  input logic [W-1:0] cfg
);
  assert_ack_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_s) |=> ack);
  assert_ack_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !act_s |=> !ack);
  assert_commit_after_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (!act_s && $past(act_s)));
  assert_bank_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(cfg));
  assert_inert_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !$past(en) && !$past(en, 2)) |-> !act_s);
endmodule

bind hostreg_if hostreg_if_chk #(.W(DW << AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .act_s(act_sy[1]),
  .ack(ack), .we(we), .cfg(cfg_q)
);

// File: tb/test_hostreg_if.sv
module test_hostreg_if;
  logic clk = 0, rst_n = 0;
  logic [2:0] mode_sel = 3'd0;
  logic cs_n = 1, ale = 0, rd_n = 1, wr_n = 1, rw_sel = 1;
  logic [4:0] addr = '0;
  logic [7:0] tb_ad = '0, tb_db = '0;
  logic ad_oe = 0, db_oe = 0;
  wire [7:0] ad, dbus;
  wire rdy, dtack_n;
  logic [255:0] cfg_q;
  int n_chk = 0, n_fail = 0;

  assign ad   = ad_oe ? tb_ad : 8'bz;
  assign dbus = db_oe ? tb_db : 8'bz;

  always #5 clk = ~clk;

  hostreg_if i_hostreg_if (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .rw_sel(rw_sel), .addr(addr), .ad(ad),
    .dbus(dbus), .rdy(rdy), .dtack_n(dtack_n), .cfg_q(cfg_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] reg_of(input int a);
    return cfg_q[a*8 +: 8];
  endfunction

  task automatic idle();
    cs_n = 1; rd_n = 1; wr_n = 1; ale = 0; rw_sel = 1; ad_oe = 0; db_oe = 0;
  endtask

  task automatic mux_addr(input logic [4:0] a);
    tb_ad = {3'b0, a}; ad_oe = 1; ale = 1; tick(3);
    ale = 0; tick(4); ad_oe = 0; tick(1);
  endtask

  task automatic t_mux_write(input logic [4:0] a, input logic [7:0] d);
    logic [7:0] old;
    mode_sel = 3'd2; idle(); tick(2);
    mux_addr(a);
    old = reg_of(a);
    tb_ad = d; ad_oe = 1; cs_n = 0; wr_n = 0; tick(6);
    chk("R8 mux rdy during write", {31'b0, rdy}, 32'd1);
    chk("R7 no commit while strobe held", {24'b0, reg_of(a)}, {24'b0, old});
    wr_n = 1; cs_n = 1; tick(1); ad_oe = 0; tick(4);
    chk("R8 mux rdy cleared", {31'b0, rdy}, 32'd0);
    chk("R3 mux write via latched addr", {24'b0, reg_of(a)}, {24'b0, d});
  endtask

  task automatic t_mux_read(input logic [4:0] a, input logic [7:0] e);
    mode_sel = 3'd2; idle(); tick(2);
    mux_addr(a);
    cs_n = 0; rd_n = 0; #1;
    chk("R4 mux read data on ad", {24'b0, ad}, {24'b0, e});
    tick(6);
    chk("R8 mux rdy during read", {31'b0, rdy}, 32'd1);
    rd_n = 1; cs_n = 1; #1;
    chk("R4 ad released after read", {24'b0, ad}, {24'b0, 8'bz});
    tick(5);
  endtask

  task automatic t_sep_write(input logic [4:0] a, input logic [7:0] d);
    mode_sel = 3'd3; idle(); tick(2);
    addr = a; tb_db = d; db_oe = 1; cs_n = 0; wr_n = 0; tick(6);
    chk("R8 sep rdy asserted", {31'b0, rdy}, 32'd1);
    wr_n = 1; cs_n = 1; tick(1); db_oe = 0; tick(4);
    chk("R5 sep write", {24'b0, reg_of(a)}, {24'b0, d});
  endtask

  task automatic t_sep_read(input logic [4:0] a, input logic [7:0] e);
    mode_sel = 3'd3; idle(); tick(2);
    addr = a; cs_n = 0; rd_n = 0; #1;
    chk("R5 sep read on dbus", {24'b0, dbus}, {24'b0, e});
    rd_n = 1; #1;
    chk("R5 dbus released with rd_n high", {24'b0, dbus}, {24'b0, 8'bz});
    cs_n = 1; tick(5);
  endtask

  task automatic t_rwb_write(input logic [4:0] a, input logic [7:0] d);
    mode_sel = 3'd4; idle(); tick(2);
    addr = a; tb_db = d; db_oe = 1; rw_sel = 0; cs_n = 0; tick(2);
    chk("R8 dtack_n not yet", {31'b0, dtack_n}, 32'd1);
    tick(4);
    chk("R8 dtack_n low", {31'b0, dtack_n}, 32'd0);
    cs_n = 1; tick(1); rw_sel = 1; db_oe = 0; tick(4);
    chk("R8 dtack_n released", {31'b0, dtack_n}, 32'd1);
    chk("R6 rwb write", {24'b0, reg_of(a)}, {24'b0, d});
  endtask

  task automatic t_rwb_read(input logic [4:0] a, input logic [7:0] e);
    mode_sel = 3'd4; idle(); tick(2);
    addr = a; rw_sel = 1; cs_n = 0; #1;
    chk("R6 rwb read on dbus", {24'b0, dbus}, {24'b0, e});
    cs_n = 1; #1;
    chk("R6 dbus released", {24'b0, dbus}, {24'b0, 8'bz});
    tick(5);
  endtask

  task automatic t_disabled();
    logic [255:0] snap;
    foreach (i_codes[k]) begin
      mode_sel = i_codes[k]; idle(); tick(2);
      snap = cfg_q;
      addr = 5'd1; tb_db = 8'hEE; db_oe = 1; tb_ad = 8'hEE; ad_oe = 1;
      cs_n = 0; wr_n = 0; rw_sel = 0; tick(6);
      chk("R1 rdy hi-z when off", {31'b0, rdy}, {31'b0, 1'bz});
      chk("R1 dtack_n hi-z when off", {31'b0, dtack_n}, {31'b0, 1'bz});
      idle(); tick(5);
      chk("R1 no write when off", {31'b0, cfg_q === snap}, 32'd1);
      cs_n = 0; rd_n = 0; rw_sel = 1; #1;
      chk("R1 dbus undriven when off", {24'b0, dbus}, {24'b0, 8'bz});
      chk("R1 ad undriven when off", {24'b0, ad}, {24'b0, 8'bz});
      idle(); tick(2);
    end
  endtask

  logic [2:0] i_codes [5] = '{3'd0, 3'd1, 3'd5, 3'd6, 3'd7};

  task automatic t_cs_ignore();
    logic [255:0] snap;
    mode_sel = 3'd3; idle(); tick(2);
    snap = cfg_q;
    addr = 5'd2; tb_db = 8'h99; db_oe = 1; wr_n = 0; tick(6);
    chk("R10 rdy idle with cs_n high", {31'b0, rdy}, 32'd0);
    wr_n = 1; tick(5);
    chk("R10 no write with cs_n high", {31'b0, cfg_q === snap}, 32'd1);
    idle(); tick(2);
  endtask

  initial begin
    tick(3); rst_n = 1; tick(2);
    chk("R2 bank zero after reset", {31'b0, cfg_q == '0}, 32'd1);
    t_mux_write(5'd7, 8'hA5);
    t_mux_read(5'd7, 8'hA5);
    t_mux_write(5'd31, 8'h3C);
    t_sep_write(5'd3, 8'h5A);
    t_sep_read(5'd3, 8'h5A);
    t_sep_read(5'd31, 8'h3C);
    t_rwb_write(5'd10, 8'hC3);
    t_rwb_read(5'd10, 8'hC3);
    t_rwb_read(5'd7, 8'hA5);
    t_sep_write(5'd4, 8'h34);
    t_rwb_write(5'd5, 8'h12);
    chk("R9 little-endian pair", {16'b0, cfg_q[47:32]}, 32'h1234);
    t_disabled();
    t_cs_ignore();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule